// File: doc/BRIEF.md
# Stack Call/Return Sequencer

This block carries out the four stack instructions of a small 8-bit processor: save the accumulator, restore the accumulator, call a subroutine and return from one. The main decoder hands it a one-cycle start pulse, a two-bit operation code, the accumulator value, the address of the instruction being executed and, for a call, the branch target. The block then owns the processor's single byte-wide memory port for a few cycles. It moves one byte per cycle, keeps the 16-bit stack pointer, and hands back an accumulator update or a new program counter. A one-cycle completion pulse tells the main state machine that it may fetch again.

The stack grows downward. A save decrements the pointer before writing, and a restore reads before incrementing. A return address takes two bytes, with its high byte at the lower address. Because only one byte moves per clock, a call and a return each pass through several dedicated states. The stack pointer can also be set from a two-byte immediate while the block is idle. The immediate arrives as a first (low) byte and a second (high) byte.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer is 0x0000, and busy, done, mem_we, a_load and pc_load are all low.
- R2: While idle and with start low, a high on sp_load sets the stack pointer to {sp_imm_hi, sp_imm_lo} on the next clock. sp_imm_lo is the first, low-order immediate byte. sp_load is ignored while busy or when start is high.
- R3: op_kind 0 (save accumulator): the cycle after start decrements SP, the next cycle writes the a_in value captured at start to the new SP, and done follows one cycle later.
- R4: op_kind 1 (restore accumulator): the cycle after start reads memory at SP and presents it with a_load high. SP then increments, and done follows in the next cycle.
- R5: op_kind 2 (call): the link value is instr_pc + 3 modulo 65536. The low link byte is written at SP-1 two cycles after start, and the high byte at SP-2 one cycle later. In the following cycle pc_load presents call_target together with done. SP ends 2 lower.
- R6: op_kind 3 (return): the high byte is read at SP and the low byte at SP+1 in consecutive cycles. One cycle later pc_load presents {high, low} together with done. SP ends 2 higher.
- R7: done lasts exactly one cycle per operation, and no memory write happens in a done cycle. pc_load and a_load never coincide with a write.
- R8: SP wraps modulo 65536 on both increment and decrement.
- R9: A start pulse that arrives while an operation is in progress is ignored. The running sequence continues unchanged, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a stack operation |
| op_kind | input | 2 | 0 save A, 1 restore A, 2 call, 3 return |
| a_in | input | 8 | Accumulator value, captured at start |
| instr_pc | input | 16 | Address of the call instruction, captured at start |
| call_target | input | 16 | Call destination, captured at start |
| sp_load | input | 1 | Set SP from the immediate while idle |
| sp_imm_lo | input | 8 | First (low) immediate byte |
| sp_imm_hi | input | 8 | Second (high) immediate byte |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as mem_addr |
| sp | output | 16 | Current stack pointer |
| a_load | output | 1 | Accumulator update strobe |
| a_value | output | 8 | New accumulator value |
| pc_load | output | 1 | Program counter update strobe |
| pc_value | output | 16 | New program counter value |
| busy | output | 1 | An operation is in progress, including its done cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check several properties. Done is a single-cycle pulse with no write beside it. The program counter and accumulator strobes appear only in cycles that do not write. The stack pointer never moves by more than one per cycle while busy, wrap included. Once an operation has begun, the block stays busy until its done cycle. Only the bench scenarios can show the rest: the byte values and addresses of each save, restore, call and return, the exact cycle each one lands in, the +3 link computation with its wrap at the top of memory, and that a stray start or stack-pointer load during a sequence leaves no trace.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPDEC,
    ST_WRITE,
    ST_READ,
    ST_WLO,
    ST_WHI,
    ST_RLO,
    ST_FIN
  } stk_state_e;

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op_kind,
  output stk_state_e state,
  output stk_op_e    op_q
);

  stk_state_e state_nx;
  stk_op_e    op_nx;

  always_comb begin
    state_nx = state;
    op_nx    = op_q;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          op_nx = stk_op_e'(op_kind);
          unique case (stk_op_e'(op_kind))
            OP_PUSH: state_nx = ST_SPDEC;
            OP_POP:  state_nx = ST_READ;
            OP_CALL: state_nx = ST_SPDEC;
            OP_RET:  state_nx = ST_READ;
          endcase
        end
      end
      ST_SPDEC: state_nx = (op_q == OP_CALL) ? ST_WLO : ST_WRITE;
      ST_WRITE: state_nx = ST_FIN;
      ST_READ:  state_nx = (op_q == OP_RET) ? ST_RLO : ST_FIN;
      ST_WLO:   state_nx = ST_WHI;
      ST_WHI:   state_nx = ST_FIN;
      ST_RLO:   state_nx = ST_FIN;
      ST_FIN:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_PUSH;
    end else begin
      state <= state_nx;
      op_q  <= op_nx;
    end
  end

endmodule

// File: rtl/stack_seq_sp.sv
module stack_seq_sp #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  input  logic              dec,
  output logic [ADDR_W-1:0] sp
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              sp_en;
  logic [ADDR_W-1:0] sp_nx;

  always_comb begin
    sp_en = load_en | inc | dec;
    if (load_en)  sp_nx = load_val;
    else if (inc) sp_nx = sp + ONE;
    else if (dec) sp_nx = sp - ONE;
    else          sp_nx = sp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp <= '0;
    else if (sp_en) sp <= sp_nx;
  end

endmodule

// File: rtl/stack_seq_data.sv
module stack_seq_data #(
  parameter int DATA_W   = 8,
  parameter int CALL_LEN = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic [DATA_W-1:0]     a_in,
  input  logic [2*DATA_W-1:0]   instr_pc,
  input  logic [2*DATA_W-1:0]   call_target,
  input  logic                  cap_hi,
  input  logic                  cap_lo,
  input  logic [DATA_W-1:0]     rdata,
  output logic [DATA_W-1:0]     a_hold,
  output logic [2*DATA_W-1:0]   link,
  output logic [2*DATA_W-1:0]   target_q,
  output logic [2*DATA_W-1:0]   ret_addr
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(CALL_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hold   <= '0;
      link     <= '0;
      target_q <= '0;
    end else if (capture) begin
      a_hold   <= a_in;
      link     <= instr_pc + STEP;
      target_q <= call_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_addr <= '0;
    end else begin
      if (cap_hi) ret_addr[ADDR_W-1:DATA_W] <= rdata;
      if (cap_lo) ret_addr[DATA_W-1:0]      <= rdata;
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CALL_LEN = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          op_kind,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [2*DATA_W-1:0] instr_pc,
  input  logic [2*DATA_W-1:0] call_target,
  input  logic                sp_load,
  input  logic [DATA_W-1:0]   sp_imm_lo,
  input  logic [DATA_W-1:0]   sp_imm_hi,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [2*DATA_W-1:0] sp,
  output logic                a_load,
  output logic [DATA_W-1:0]   a_value,
  output logic                pc_load,
  output logic [2*DATA_W-1:0] pc_value,
  output logic                busy,
  output logic                done
);

  localparam int ADDR_W = 2 * DATA_W;

  stk_state_e        state;
  stk_op_e           op_q;
  logic              idle;
  logic              accept;
  logic              sp_set;
  logic              sp_inc;
  logic              sp_dec;
  logic              cap_hi;
  logic              cap_lo;
  logic [DATA_W-1:0] a_hold;
  logic [ADDR_W-1:0] link;
  logic [ADDR_W-1:0] target_q;
  logic [ADDR_W-1:0] ret_addr;

  assign idle   = (state == ST_IDLE);
  assign accept = idle & start;
  assign sp_set = idle & ~start & sp_load;

  stack_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .op_kind (op_kind),
    .state   (state),
    .op_q    (op_q)
  );

  stack_seq_sp #(.ADDR_W(ADDR_W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (sp_set),
    .load_val ({sp_imm_hi, sp_imm_lo}),
    .inc      (sp_inc),
    .dec      (sp_dec),
    .sp       (sp)
  );

  stack_seq_data #(.DATA_W(DATA_W), .CALL_LEN(CALL_LEN)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (accept),
    .a_in        (a_in),
    .instr_pc    (instr_pc),
    .call_target (call_target),
    .cap_hi      (cap_hi),
    .cap_lo      (cap_lo),
    .rdata       (mem_rdata),
    .a_hold      (a_hold),
    .link        (link),
    .target_q    (target_q),
    .ret_addr    (ret_addr)
  );

  always_comb begin
    mem_addr  = sp;
    mem_we    = 1'b0;
    mem_wdata = '0;
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    cap_hi    = 1'b0;
    cap_lo    = 1'b0;
    a_load    = 1'b0;
    a_value   = '0;
    pc_load   = 1'b0;
    pc_value  = '0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: ;
      ST_SPDEC: sp_dec = 1'b1;
      ST_WRITE: begin
        mem_we    = 1'b1;
        mem_wdata = a_hold;
      end
      ST_READ: begin
        sp_inc = 1'b1;
        if (op_q == OP_POP) begin
          a_load  = 1'b1;
          a_value = mem_rdata;
        end else begin
          cap_hi = 1'b1;
        end
      end
      ST_WLO: begin
        mem_we    = 1'b1;
        mem_wdata = link[DATA_W-1:0];
        sp_dec    = 1'b1;
      end
      ST_WHI: begin
        mem_we    = 1'b1;
        mem_wdata = link[ADDR_W-1:DATA_W];
      end
      ST_RLO: begin
        cap_lo = 1'b1;
        sp_inc = 1'b1;
      end
      ST_FIN: begin
        done = 1'b1;
        if (op_q == OP_CALL) begin
          pc_load  = 1'b1;
          pc_value = target_q;
        end else if (op_q == OP_RET) begin
          pc_load  = 1'b1;
          pc_value = ret_addr;
        end
      end
      default: ;
    endcase
  end

  assign busy = ~idle;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              busy,
  input logic              mem_we,
  input logic              pc_load,
  input logic              a_load,
  input logic [ADDR_W-1:0] sp
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  assert_done_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_pc_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (done && !mem_we));

  assert_aload_noread_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    a_load |-> (!mem_we && !done && busy));

  assert_sp_step_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((sp == $past(sp)) || (sp == $past(sp) + ONE) || (sp == $past(sp) - ONE)));

  assert_hold_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind stack_seq stack_seq_chk #(.ADDR_W(2*DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (done),
  .busy    (busy),
  .mem_we  (mem_we),
  .pc_load (pc_load),
  .a_load  (a_load),
  .sp      (sp)
);

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [7:0]  a_in = 8'd0;
  logic [15:0] instr_pc = 16'd0;
  logic [15:0] call_target = 16'd0;
  logic        sp_load = 1'b0;
  logic [7:0]  sp_imm_lo = 8'd0;
  logic [7:0]  sp_imm_hi = 8'd0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic [15:0] sp;
  logic        a_load;
  logic [7:0]  a_value;
  logic        pc_load;
  logic [15:0] pc_value;
  logic        busy;
  logic        done;

  always #2.5 clk = ~clk;

  stack_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind), .a_in(a_in),
    .instr_pc(instr_pc), .call_target(call_target), .sp_load(sp_load),
    .sp_imm_lo(sp_imm_lo), .sp_imm_hi(sp_imm_hi), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp(sp),
    .a_load(a_load), .a_value(a_value), .pc_load(pc_load), .pc_value(pc_value),
    .busy(busy), .done(done)
  );

  // Environment memory (256 bytes, aliased) and an independent reference copy
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    cy;
    int    kind;   // 0 write, 1 accumulator, 2 program counter, 3 done
    int    addr;
    int    data;
    string req;
  } ev_t;

  ev_t expq[$];
  int checks = 0;
  int errors = 0;
  logic [15:0] sp_m = 16'd0;
  bit prev_done = 1'b0;

  task automatic expect_ev(int c, int k, int a, int d, string r);
    ev_t e;
    e.cy = c; e.kind = k; e.addr = a; e.data = d; e.req = r;
    expq.push_back(e);
  endtask

  task automatic got_ev(int k, int a, int d);
    ev_t e;
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL R9: unexpected event kind=%0d addr=%h data=%h at cycle %0d, expected none",
               k, a, d, cyc);
    end else begin
      e = expq.pop_front();
      if (e.cy != cyc || e.kind != k || e.addr != a || e.data != d) begin
        errors++;
        $display("FAIL %s: got kind=%0d addr=%h data=%h cycle=%0d, expected kind=%0d addr=%h data=%h cycle=%0d",
                 e.req, k, a, d, cyc, e.kind, e.addr, e.data, e.cy);
      end
    end
  endtask

  task automatic chk(int got, int exp, string r);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  // Monitor: samples outputs mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we)  got_ev(0, int'(mem_addr), int'(mem_wdata));
      if (a_load)  got_ev(1, 0, int'(a_value));
      if (pc_load) got_ev(2, 0, int'(pc_value));
      if (done) begin
        got_ev(3, 0, 0);
        chk(int'(mem_we), 0, "R7 write in done cycle");
        chk(int'(prev_done), 0, "R7 done longer than one cycle");
      end
      prev_done = done;
    end
  end

  task automatic load_sp(logic [15:0] v, string r);
    @(negedge clk);
    sp_load = 1'b1; sp_imm_lo = v[7:0]; sp_imm_hi = v[15:8];
    @(negedge clk);
    sp_load = 1'b0;
    sp_m = v;
    chk(int'(sp), int'(v), r);
  endtask

  task automatic run_op(logic [1:0] k, logic [7:0] a, logic [15:0] ipc,
                        logic [15:0] tgt, bit disturb, string r);
    int c0;
    logic [15:0] lnk;
    logic [7:0] hi;
    logic [7:0] lo;
    @(negedge clk);
    c0 = cyc;
    start = 1'b1; op_kind = k; a_in = a; instr_pc = ipc; call_target = tgt;
    case (k)
      2'd0: begin  // R3
        sp_m = sp_m - 16'd1;
        expect_ev(c0 + 2, 0, int'(sp_m), int'(a), "R3 push write");
        ref_mem[sp_m[7:0]] = a;
        expect_ev(c0 + 3, 3, 0, 0, "R3 push done");
      end
      2'd1: begin  // R4
        expect_ev(c0 + 1, 1, 0, int'(ref_mem[sp_m[7:0]]), "R4 pop value");
        sp_m = sp_m + 16'd1;
        expect_ev(c0 + 2, 3, 0, 0, "R4 pop done");
      end
      2'd2: begin  // R5
        lnk = ipc + 16'd3;
        sp_m = sp_m - 16'd1;
        expect_ev(c0 + 2, 0, int'(sp_m), int'(lnk[7:0]), "R5 call low byte");
        ref_mem[sp_m[7:0]] = lnk[7:0];
        sp_m = sp_m - 16'd1;
        expect_ev(c0 + 3, 0, int'(sp_m), int'(lnk[15:8]), "R5 call high byte");
        ref_mem[sp_m[7:0]] = lnk[15:8];
        expect_ev(c0 + 4, 2, 0, int'(tgt), "R5 call target");
        expect_ev(c0 + 4, 3, 0, 0, "R5 call done");
      end
      default: begin  // R6
        hi = ref_mem[sp_m[7:0]];
        sp_m = sp_m + 16'd1;
        lo = ref_mem[sp_m[7:0]];
        sp_m = sp_m + 16'd1;
        expect_ev(c0 + 3, 2, 0, int'({hi, lo}), "R6 return address");
        expect_ev(c0 + 3, 3, 0, 0, "R6 return done");
      end
    endcase
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin  // R9: stray start and stack-pointer load while busy
      start = 1'b1; op_kind = 2'd1; sp_load = 1'b1;
      sp_imm_lo = 8'h55; sp_imm_hi = 8'hAA;
      @(negedge clk);
      start = 1'b0; sp_load = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(int'(sp), int'(sp_m), r);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(sp), 0, "R1 sp");
    chk(int'(busy), 0, "R1 busy");
    chk(int'(done), 0, "R1 done");
    chk(int'(mem_we), 0, "R1 mem_we");
    chk(int'({a_load, pc_load}), 0, "R1 strobes");
    rst_n = 1'b1;
    @(negedge clk);

    load_sp(16'h0040, "R2 sp load");
    run_op(2'd0, 8'h5A, 16'h0, 16'h0, 1'b0, "R3 sp after push");
    run_op(2'd0, 8'hC3, 16'h0, 16'h0, 1'b0, "R3 sp after second push");
    run_op(2'd1, 8'h00, 16'h0, 16'h0, 1'b0, "R4 sp after pop");
    run_op(2'd2, 8'h00, 16'h1234, 16'h2000, 1'b0, "R5 sp after call");
    run_op(2'd3, 8'h00, 16'h0, 16'h0, 1'b0, "R6 sp after return");
    run_op(2'd2, 8'h00, 16'hFFFE, 16'h0ABC, 1'b0, "R5 sp after call with link wrap");
    run_op(2'd3, 8'h00, 16'h0, 16'h0, 1'b0, "R6 sp after return with wrapped link");

    // R8 wrap of the stack pointer
    load_sp(16'h0000, "R2 sp load zero");
    run_op(2'd0, 8'h77, 16'h0, 16'h0, 1'b0, "R8 push wraps sp to FFFF");
    run_op(2'd1, 8'h00, 16'h0, 16'h0, 1'b0, "R8 pop wraps sp to 0000");
    load_sp(16'h0001, "R2 sp load one");
    run_op(2'd2, 8'h00, 16'h4000, 16'h1111, 1'b0, "R8 call crosses zero");
    run_op(2'd3, 8'h00, 16'h0, 16'h0, 1'b0, "R8 return crosses zero");

    // R9 stray requests while busy
    load_sp(16'h0080, "R2 sp load 0080");
    run_op(2'd0, 8'h9E, 16'h0, 16'h0, 1'b1, "R9 push ignores stray start and sp load");
    run_op(2'd2, 8'h00, 16'h0100, 16'h0300, 1'b1, "R9 call ignores stray start and sp load");
    run_op(2'd3, 8'h00, 16'h0, 16'h0, 1'b0, "R6 return after disturbed call");

    // R2: sp_load together with start is ignored
    @(negedge clk);
    start = 1'b1; op_kind = 2'd1; sp_load = 1'b1; sp_imm_lo = 8'h12; sp_imm_hi = 8'h34;
    expect_ev(cyc + 1, 1, 0, int'(ref_mem[sp_m[7:0]]), "R4 pop with simultaneous sp load");
    sp_m = sp_m + 16'd1;
    expect_ev(cyc + 2, 3, 0, 0, "R4 pop done");
    @(negedge clk);
    start = 1'b0; sp_load = 1'b0;
    while (!done) @(negedge clk);
    chk(int'(sp), int'(sp_m), "R2 sp load ignored beside start");

    repeat (4) @(negedge clk);
    chk(expq.size(), 0, "R7 all expected events seen");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule